// File: doc/BRIEF.md
# Real-Time Clock Periodic Interrupt and Interrupt Flags

This block turns a reference timebase into the internal 32768 Hz base tick of a real-time clock, derives from it a selectable periodic event, a square wave and a once-per-second update tick, and keeps the interrupt flag register. The reference is presented as a one-cycle `ref_tick` strobe per reference period. A 3-bit divider field picks how many reference periods form one base tick (128, 32 or 1), holds the chain in reset, or freezes it. A 4-bit rate field picks a periodic interval of 2^(r-1) base ticks for r from 1 to 15, or turns the periodic event off.

Three sources raise flags: the periodic event, an alarm pulse and an update-ended pulse, both pulses supplied by the neighbouring time and alarm logic. Each flag sets whatever its enable. A summary bit ORs the enabled flags and drives an active-low interrupt pin. A read strobe on the flag register clears all flags, but an event in the very cycle of the read survives. The `sec_tick` pulse tells the time counters when to advance.

Top module: `rtc_pit_flags`

## Requirements
- R1: `freq_reg[6:4]` selects the base-tick divider: code 0 forms one base tick every 128 `ref_tick` strobes, code 1 every 32, code 2 every strobe.
- R2: Divider codes 6 and 7 hold the chain in reset (no periodic event, no `sec_tick`, counters reloaded); codes 3, 4 and 5 freeze the chain, producing no events while they are set.
- R3: `freq_reg[3:0]` = 0 gives no periodic event; a value r in 1..15 gives a periodic event every 2^(r-1) base ticks, the first one 2^(r-1) base ticks after the chain leaves reset.
- R4: `sec_tick` is a one-cycle pulse every 2^SEC_BITS base ticks (32768 by default); the first one comes 2^(SEC_BITS-1) base ticks after the chain leaves reset.
- R5: With `ctrl_bits[3]` set and rate r in 2..15, `sqw` is low for the first half and high for the second half of each periodic interval; at r = 1 it toggles on every base tick; with `ctrl_bits[3]` clear or r = 0 it is low.
- R6: `flags_out` bit 6 is the periodic flag, bit 5 the alarm flag (set by `alarm_evt`), bit 4 the update-ended flag (set by `upd_done_evt`); each sets on the clock edge of its event regardless of enables, and bits 3:0 read 0.
- R7: `flags_out` bit 7 is the OR of the flags whose enables are set (`ctrl_bits[6]` periodic, `ctrl_bits[5]` alarm, `ctrl_bits[4]` update-ended), and `irq_n` is its inverse.
- R8: A cycle with `rd_flags` high clears bits 6:4 at the next edge, except that an event in that same cycle leaves its flag set.
- R9: After reset, `flags_out` is 0, `irq_n` is 1, `sqw` and `sec_tick` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | One-cycle strobe per reference period |
| freq_reg | input | 7 | Bits 6:4 divider control, bits 3:0 rate select |
| ctrl_bits | input | 4 | Bit 6 periodic enable, 5 alarm enable, 4 update-ended enable, 3 square-wave enable |
| alarm_evt | input | 1 | Alarm match pulse |
| upd_done_evt | input | 1 | Update-ended pulse from the time counters |
| rd_flags | input | 1 | Read strobe for the flag register (clears it) |
| flags_out | output | 8 | Flag register read value |
| irq_n | output | 1 | Active-low interrupt request |
| sqw | output | 1 | Square-wave output |
| sec_tick | output | 1 | One-second update pulse to the time counters |

## Verification
Event pulses, `sec_tick` and the square wave follow the counter registers combinationally, so they are visible in the cycle that precedes the counter edge that causes them; flags, and with them `irq_n` and bit 7, appear one edge after their event. With a strobe every cycle in code 2, the periodic flag is therefore first seen at the falling edge after T = P*2^(r-1) rising edges from release, and `sec_tick` at the falling edge after edge 16383. The bench drives all inputs on falling edges, counts falling edges from the release of the divider, and compares the counts with these numbers exactly, which also fixes the spacing between events and the clear-on-read edge.

// File: rtl/rtcp_pkg.sv
`timescale 1ns/1ps
package rtcp_pkg;

  typedef enum logic [1:0] {
    CH_RUN    = 2'd0,
    CH_FREEZE = 2'd1,
    CH_RESET  = 2'd2
  } chain_st_e;

  // divider code -> chain state
  function automatic chain_st_e chain_state(input logic [2:0] dv);
    case (dv)
      3'd0, 3'd1, 3'd2: return CH_RUN;
      3'd6, 3'd7:       return CH_RESET;
      default:          return CH_FREEZE;
    endcase
  endfunction

  // log2 of the reference strobes per base tick
  function automatic int unsigned pre_log2(input logic [2:0] dv,
                                           input int unsigned hi,
                                           input int unsigned mid);
    case (dv)
      3'd0:    return hi;
      3'd1:    return mid;
      default: return 0;
    endcase
  endfunction

  // n low bits set
  function automatic logic [31:0] low_ones(input int unsigned n);
    if (n == 0) return '0;
    return 32'hFFFF_FFFF >> (32 - n);
  endfunction

  // counter bits that must wrap for a periodic event at rate r
  function automatic logic [31:0] rate_mask(input logic [3:0] r);
    if (r == 4'd0) return '0;
    return low_ones(int'(r) - 1);
  endfunction

  // square-wave phase: the bit that rises at the middle of the interval
  function automatic logic sq_phase(input logic [31:0] cnt, input logic [3:0] r);
    if (r < 4'd2) return 1'b0;
    return cnt[5'(r) - 5'd2];
  endfunction

endpackage

// File: rtl/rtcp_prescale.sv
`timescale 1ns/1ps
module rtcp_prescale
  import rtcp_pkg::*;
#(
  parameter int unsigned HI_LOG2  = 7,
  parameter int unsigned MID_LOG2 = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_tick,
  input  logic       run,
  input  logic       clr,
  input  logic [2:0] dv,
  output logic       base_tick
);
  localparam int unsigned PW = (HI_LOG2 > MID_LOG2) ? HI_LOG2 : MID_LOG2;

  logic [PW-1:0] pre_cnt;
  logic [31:0]   term_mask;
  logic          at_term;

  always_comb begin
    term_mask = low_ones(pre_log2(dv, HI_LOG2, MID_LOG2));
    at_term   = ((32'(pre_cnt) & term_mask) == term_mask);
    base_tick = run && ref_tick && at_term;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pre_cnt <= '0;
    else if (clr)              pre_cnt <= '0;
    else if (run && ref_tick)  pre_cnt <= pre_cnt + 1'b1;
  end
endmodule

// File: rtl/rtcp_divchain.sv
`timescale 1ns/1ps
module rtcp_divchain
  import rtcp_pkg::*;
#(
  parameter int unsigned SEC_BITS = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       base_tick,
  input  logic [3:0] rate,
  input  logic       sq_en,
  output logic       per_evt,
  output logic       sec_tick,
  output logic       sqw
);
  localparam logic [SEC_BITS-1:0] HALF = SEC_BITS'(1) << (SEC_BITS - 1);

  logic [SEC_BITS-1:0] div_cnt;
  logic [SEC_BITS-1:0] div_nxt;
  logic                fast_tgl;

  always_comb begin
    div_nxt  = div_cnt + 1'b1;
    per_evt  = base_tick && (rate != 4'd0) &&
               ((32'(div_nxt) & rate_mask(rate)) == 32'd0);
    sec_tick = base_tick && (&div_cnt);
    if (!sq_en)              sqw = 1'b0;
    else if (rate == 4'd1)   sqw = fast_tgl;
    else                     sqw = sq_phase(32'(div_cnt), rate);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt  <= HALF;
      fast_tgl <= 1'b0;
    end else if (clr) begin
      div_cnt  <= HALF;
      fast_tgl <= 1'b0;
    end else if (base_tick) begin
      div_cnt  <= div_nxt;
      fast_tgl <= ~fast_tgl;
    end
  end
endmodule

// File: rtl/rtcp_flags.sv
`timescale 1ns/1ps
module rtcp_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] evt,     // {periodic, alarm, update-ended}
  input  logic [2:0] en,
  input  logic       rd_clr,
  output logic [2:0] flag_q,
  output logic       irqf
);
  assign irqf = |(flag_q & en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= (rd_clr ? 3'b000 : flag_q) | evt;
  end
endmodule

// File: rtl/rtc_pit_flags.sv
`timescale 1ns/1ps
module rtc_pit_flags
  import rtcp_pkg::*;
#(
  parameter int unsigned HI_LOG2  = 7,
  parameter int unsigned MID_LOG2 = 5,
  parameter int unsigned SEC_BITS = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_tick,
  input  logic [6:0] freq_reg,
  input  logic [6:3] ctrl_bits,
  input  logic       alarm_evt,
  input  logic       upd_done_evt,
  input  logic       rd_flags,
  output logic [7:0] flags_out,
  output logic       irq_n,
  output logic       sqw,
  output logic       sec_tick
);
  chain_st_e  chain_st;
  logic       chain_run;
  logic       chain_clr;
  logic       base_tick;
  logic       per_evt;
  logic [2:0] flag_q;
  logic       irqf;

  assign chain_st  = chain_state(freq_reg[6:4]);
  assign chain_run = (chain_st == CH_RUN);
  assign chain_clr = (chain_st == CH_RESET);

  rtcp_prescale #(.HI_LOG2(HI_LOG2), .MID_LOG2(MID_LOG2)) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_tick  (ref_tick),
    .run       (chain_run),
    .clr       (chain_clr),
    .dv        (freq_reg[6:4]),
    .base_tick (base_tick)
  );

  rtcp_divchain #(.SEC_BITS(SEC_BITS)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (chain_clr),
    .base_tick (base_tick),
    .rate      (freq_reg[3:0]),
    .sq_en     (ctrl_bits[3]),
    .per_evt   (per_evt),
    .sec_tick  (sec_tick),
    .sqw       (sqw)
  );

  rtcp_flags u_flg (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt    ({per_evt, alarm_evt, upd_done_evt}),
    .en     (ctrl_bits[6:4]),
    .rd_clr (rd_flags),
    .flag_q (flag_q),
    .irqf   (irqf)
  );

  assign flags_out = {irqf, flag_q, 4'b0000};
  assign irq_n     = ~irqf;
endmodule

// File: rtl/rtc_pit_flags_chk.sv
`timescale 1ns/1ps
module rtc_pit_flags_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [6:0] freq_reg,
  input logic [6:3] ctrl_bits,
  input logic       alarm_evt,
  input logic       upd_done_evt,
  input logic       rd_flags,
  input logic [7:0] flags_out,
  input logic       irq_n,
  input logic       sqw,
  input logic       sec_tick,
  input logic       per_evt
);
  a_r2_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_reg[6:5] == 2'b11) |-> (!per_evt && !sec_tick));

  a_r3_rate_off: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_reg[3:0] == 4'd0) |-> !per_evt);

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> !sec_tick);

  a_r5_sq_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_bits[3] |-> !sqw);

  a_r6_alarm_sets: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_evt |=> flags_out[5]);

  a_r6_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    flags_out[3:0] == 4'b0000);

  a_r7_no_enable_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_bits[6:4] == 3'b000) |-> irq_n);

  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_flags && !per_evt && !alarm_evt && !upd_done_evt) |=> (flags_out[6:4] == 3'b000));

  a_r8_event_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_flags && upd_done_evt) |=> flags_out[4]);
endmodule

bind rtc_pit_flags rtc_pit_flags_chk u_chk (.*);

// File: tb/test_rtc_pit_flags.sv
`timescale 1ns/1ps
module test_rtc_pit_flags;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_tick = 1'b1;
  logic [6:0] freq = 7'h60;
  logic [6:3] ctrl = 4'b0000;
  logic       alarm = 1'b0;
  logic       upd = 1'b0;
  logic       rd = 1'b0;
  logic [7:0] flags_out;
  logic       irq_n, sqw, sec_tick;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  rtc_pit_flags i_rtc_pit_flags (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .freq_reg(freq),
    .ctrl_bits(ctrl), .alarm_evt(alarm), .upd_done_evt(upd), .rd_flags(rd),
    .flags_out(flags_out), .irq_n(irq_n), .sqw(sqw), .sec_tick(sec_tick)
  );

  // {divider code, rate, expected falling edges = P * 2^(rate-1)}
  localparam int NV = 6;
  localparam int VEC [NV][3] = '{
    '{2, 1, 1}, '{2, 4, 8}, '{1, 3, 128}, '{0, 2, 256}, '{2, 8, 128}, '{1, 1, 32}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_rd();
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic hold_chain(input logic [3:0] rate);
    freq = {3'd6, rate};
    pulse_rd();
    @(negedge clk);
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (irq_n && n < 2000);
  endtask

  task automatic wait_sec(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!sec_tick && n < 40000);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 flags", 32'(flags_out), 0);
    chk("R9 irq_n", 32'(irq_n), 1);
    chk("R9 sqw", 32'(sqw), 0);
    chk("R9 sec_tick", 32'(sec_tick), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R3 R7 R8: vector table
    for (int i = 0; i < NV; i++) begin
      ctrl = 4'b1000;
      hold_chain(4'(VEC[i][1]));
      chk("R2 held in reset", 32'(irq_n), 1);
      freq[6:4] = 3'(VEC[i][0]);
      wait_irq(n);
      chk("R1/R3 first periodic", n, VEC[i][2]);
      chk("R6/R7 flag value", 32'(flags_out), 32'hC0);
      pulse_rd();
      n = 1;
      if (VEC[i][2] > 1) chk("R8 cleared by read", 32'(flags_out), 0);
      while (irq_n && n < 2000) begin @(negedge clk); n++; end
      chk("R3/R8 next periodic", n, VEC[i][2]);
    end

    // R3 rate 0: no periodic event
    hold_chain(4'd0);
    freq[6:4] = 3'd2;
    repeat (50) @(negedge clk);
    chk("R3 rate off", 32'(flags_out), 0);

    // R2 freeze codes
    ctrl = 4'b1000;
    hold_chain(4'd1);
    freq[6:4] = 3'd2;
    repeat (5) @(negedge clk);
    freq[6:4] = 3'd4;
    pulse_rd();
    repeat (20) @(negedge clk);
    chk("R2 frozen no events", 32'(flags_out), 0);

    // R4 update tick
    ctrl = 4'b0000;
    hold_chain(4'd0);
    freq[6:4] = 3'd2;
    wait_sec(n);
    chk("R4 first sec_tick", n, 16383);
    @(negedge clk);
    chk("R4 pulse one cycle", 32'(sec_tick), 0);
    n = 1;
    while (!sec_tick && n < 40000) begin @(negedge clk); n++; end
    chk("R4 sec_tick period", n, 32768);

    // R5 square wave, rate 4: high during edges 4..7 of each 8
    ctrl = 4'b0001;
    hold_chain(4'd4);
    freq[6:4] = 3'd2;
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      if (k == 3) chk("R5 sq low half", 32'(sqw), 0);
      if (k == 4) chk("R5 sq rises mid", 32'(sqw), 1);
      if (k == 7) chk("R5 sq high half", 32'(sqw), 1);
      if (k == 8) chk("R5 sq falls at end", 32'(sqw), 0);
    end
    repeat (4) @(negedge clk);
    ctrl = 4'b0000;
    #1 chk("R5 sq disabled", 32'(sqw), 0);
    // rate 1: toggles per base tick
    ctrl = 4'b0001;
    hold_chain(4'd1);
    freq[6:4] = 3'd2;
    @(negedge clk);
    chk("R5 fast toggle 1", 32'(sqw), 1);
    @(negedge clk);
    chk("R5 fast toggle 2", 32'(sqw), 0);

    // R6 R7 R8 alarm and update-ended sources
    ctrl = 4'b0100;
    hold_chain(4'd0);
    upd = 1'b1;
    @(negedge clk);
    upd = 1'b0;
    chk("R6 update flag unmasked only", 32'(flags_out), 32'h10);
    chk("R7 disabled no irq", 32'(irq_n), 1);
    alarm = 1'b1;
    @(negedge clk);
    alarm = 1'b0;
    chk("R6/R7 alarm enabled", 32'(flags_out), 32'hB0);
    chk("R7 irq asserted", 32'(irq_n), 0);
    rd = 1'b1;
    alarm = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    alarm = 1'b0;
    chk("R8 same-cycle event kept", 32'(flags_out), 32'hA0);
    pulse_rd();
    chk("R8 read clears", 32'(flags_out), 0);
    chk("R7 irq released", 32'(irq_n), 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule